// File: doc/BRIEF.md
# Clock-Rate Power Manager with Switchback

This block produces the machine-cycle enable, `cyc_en`, for a small microcontroller core. Every clocked function in the core, timers included, advances only on that enable. In standard mode the enable fires once every 4 input clocks. In low-power mode it fires once every 1024 input clocks, so instructions keep executing at a much lower rate. Software picks the rate through a two-bit divide field in a configuration register. Writing the standard code leaves low-power mode.

A switchback-enable bit lets hardware restore the standard rate on its own while low-power mode is selected. Three events trigger this: an interrupt acknowledge from the interrupt controller, a start bit seen by a UART receiver that is enabled, and a load of the serial transmit buffer. Each of these rewrites the divide field to the standard code, so software reads back the mode now in force. This brings the baud timers up to speed before a character is shifted.

A rate change waits for the end of the machine cycle that is under way, so no enable pulse is ever shortened or stretched. A read-only status byte shows which interrupt priority levels are in service and whether serial activity is pending.

Top module: `clk_rate_mgr`

## Requirements
- R1: After reset `cfg_rdata` reads 8'h40: the divide field in bits [7:6] is 2'b01, the switchback-enable bit 5 is 0, and bits [4:0] always read 0. With the field at 2'b01, `cyc_en` is high for one clock in every 4, first on the 4th clock after reset is released.
- R2: When the divide field reads 2'b11 (low-power), `cyc_en` is high for one clock in every 1024 clocks and `lp_active` reads 1. Any other field value selects the standard rate.
- R3: A new rate takes effect only on the clock after a `cyc_en` pulse. The spacing between two consecutive pulses is always exactly 4 or exactly 1024 clocks, and `lp_active` changes only right after a pulse.
- R4: A clock edge with `cfg_we` high loads `cfg_wdata[7:6]` into the divide field and `cfg_wdata[5]` into switchback-enable. Writing field 2'b01 returns the block to the standard rate.
- R5: With switchback-enable 1 and the field at 2'b11, a one-clock `irq_ack` makes the field read 2'b01 on the next clock.
- R6: With switchback-enable 1 and the field at 2'b11, `rx_start` while `rx_en` is 1 makes the field read 2'b01 on the next clock. `rx_start` while `rx_en` is 0 changes nothing.
- R7: With switchback-enable 1 and the field at 2'b11, `tx_load` makes the field read 2'b01 on the next clock.
- R8: With switchback-enable 0, no trigger strobe changes the configuration or the rate. A request that is masked or disabled produces no `irq_ack`, and therefore has no effect either.
- R9: When a switchback event and a software write fall on the same clock, the divide field becomes 2'b01 and the switchback-enable bit takes the written value.
- R10: `stat_rdata` shows power-fail in service at bit 7, high priority in service at bit 6, low priority in service at bit 5, and serial activity pending at bit 0. Bits [4:1] read 0. The byte follows its inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data: [7:6] divide field, [5] switchback enable |
| cfg_rdata | output | 8 | Configuration readback |
| irq_ack | input | 1 | Interrupt acknowledge strobe from the interrupt controller |
| rx_en | input | 1 | UART receiver enabled |
| rx_start | input | 1 | Start bit detected strobe |
| tx_load | input | 1 | Serial transmit buffer load strobe |
| isr_pf | input | 1 | Power-fail level in service |
| isr_hi | input | 1 | High priority level in service |
| isr_lo | input | 1 | Low priority level in service |
| ser_busy | input | 1 | Serial activity pending |
| stat_rdata | output | 8 | Read-only status byte |
| cyc_en | output | 1 | Machine-cycle enable pulse |
| lp_active | output | 1 | Low-power rate currently in effect |

## Verification
The assertions check on every cycle that each qualified trigger forces the standard code on the next clock. They also check that a register with switchback disabled and no write holds its value, that the active rate moves only right after an enable pulse, and that a standard-rate pulse is never followed at once by another. Only the bench scenarios can show the full pulse spacing of 4 and 1024 clocks and how long switchback takes to reach the enable output for each source. They also show that strobes with switchback disabled or the receiver off leave low-power running, and how a simultaneous write and trigger resolve.

// File: rtl/crm_pkg.sv
// Shared types and constants for the clock-rate power manager.
// Assumes an 8-bit configuration byte with the divide field at [7:6].
package crm_pkg;
    localparam logic [1:0] DIV_STD = 2'b01;
    localparam logic [1:0] DIV_LP  = 2'b11;
    localparam int         CFG_DIV_LSB = 6;
    localparam int         CFG_SWB_BIT = 5;

    typedef struct packed {
        logic [1:0] div;
        logic       swb;
    } cfg_t;
endpackage

// File: rtl/crm_cfg_reg.sv
// Configuration register: divide field and switchback enable.
// Assumes a switchback event outranks a simultaneous software write on the divide field.
module crm_cfg_reg
    import crm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       sb_evt,
    output cfg_t       cfg
);
    // Load software writes, then let hardware switchback override the field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.div <= DIV_STD;
            cfg.swb <= 1'b0;
        end else begin
            if (we) begin
                cfg.div <= wdata[CFG_DIV_LSB +: 2];
                cfg.swb <= wdata[CFG_SWB_BIT];
            end
            if (sb_evt) begin
                cfg.div <= DIV_STD;
            end
        end
    end

    p_sb_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_evt && we) |=> (cfg.div == DIV_STD && cfg.swb == $past(wdata[CFG_SWB_BIT])));
endmodule

// File: rtl/crm_switchback.sv
// Switchback trigger qualification: any qualified source while low-power is selected.
// Assumes all source strobes are single-clock and synchronous to clk.
module crm_switchback #(
    parameter int NSRC = 3
) (
    input  logic            swb,
    input  logic            lp_sel,
    input  logic [NSRC-1:0] src,
    output logic            sb_evt
);
    logic [NSRC:0] any_chain;

    assign any_chain[0] = 1'b0;
    // OR-reduce the qualified trigger sources.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign any_chain[i+1] = any_chain[i] | src[i];
    end

    // Fire only with switchback enabled and low-power selected.
    always_comb sb_evt = swb && lp_sel && any_chain[NSRC];
endmodule

// File: rtl/crm_cycle_div.sv
// Machine-cycle divider: one enable pulse per STD_DIV or LP_DIV clocks.
// Assumes the requested rate is sampled only on the last clock of a machine cycle.
module crm_cycle_div #(
    parameter int STD_DIV = 4,
    parameter int LP_DIV  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req,
    output logic cyc_en,
    output logic lp_act
);
    localparam int CNT_W = $clog2(LP_DIV);
    localparam logic [CNT_W-1:0] STD_LAST = CNT_W'(STD_DIV - 1);
    localparam logic [CNT_W-1:0] LP_LAST  = CNT_W'(LP_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_end;

    // Detect the final clock of the current machine cycle.
    always_comb at_end = (cnt == (lp_act ? LP_LAST : STD_LAST));

    // Count clocks; restart and adopt the requested rate at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            lp_act <= 1'b0;
        end else if (at_end) begin
            cnt    <= '0;
            lp_act <= lp_req;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cyc_en = at_end;

    p_rate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(lp_act));
    p_std_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !lp_act) |=> !cyc_en);
endmodule

// File: rtl/clk_rate_mgr.sv
// Clock-rate power manager top: configuration, switchback and cycle divider.
// Assumes the trigger and status inputs are already synchronous to clk.
module clk_rate_mgr
    import crm_pkg::*;
#(
    parameter int STD_DIV = 4,
    parameter int LP_DIV  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       irq_ack,
    input  logic       rx_en,
    input  logic       rx_start,
    input  logic       tx_load,
    input  logic       isr_pf,
    input  logic       isr_hi,
    input  logic       isr_lo,
    input  logic       ser_busy,
    output logic [7:0] stat_rdata,
    output logic       cyc_en,
    output logic       lp_active
);
    cfg_t       cfg;
    logic       sb_evt;
    logic [2:0] trig;

    // Collect the three qualified switchback sources.
    always_comb trig = {tx_load, rx_en && rx_start, irq_ack};

    crm_switchback #(.NSRC(3)) u_sb (
        .swb    (cfg.swb),
        .lp_sel (cfg.div == DIV_LP),
        .src    (trig),
        .sb_evt (sb_evt)
    );

    crm_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .sb_evt (sb_evt),
        .cfg    (cfg)
    );

    crm_cycle_div #(.STD_DIV(STD_DIV), .LP_DIV(LP_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .lp_req (cfg.div == DIV_LP),
        .cyc_en (cyc_en),
        .lp_act (lp_active)
    );

    // Assemble the configuration readback byte.
    always_comb cfg_rdata = {cfg.div, cfg.swb, 5'b0};

    // Assemble the read-only status byte.
    always_comb stat_rdata = {isr_pf, isr_hi, isr_lo, 4'b0, ser_busy};

    p_irq_sb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.swb && cfg.div == DIV_LP && irq_ack) |=> (cfg_rdata[7:6] == DIV_STD));
    p_rx_sb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.swb && cfg.div == DIV_LP && rx_en && rx_start) |=> (cfg_rdata[7:6] == DIV_STD));
    p_tx_sb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.swb && cfg.div == DIV_LP && tx_load) |=> (cfg_rdata[7:6] == DIV_STD));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !cfg.swb) |=> $stable(cfg_rdata));
    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !sb_evt) |=> (cfg_rdata[7:5] == $past(cfg_wdata[7:5])));
endmodule

// File: tb/tb_clk_rate_mgr.sv
// Bench: behavioural reference model compared against the design on every clock.
module tb_clk_rate_mgr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       irq_ack = 1'b0, rx_en = 1'b0, rx_start = 1'b0, tx_load = 1'b0;
    logic       isr_pf = 1'b0, isr_hi = 1'b0, isr_lo = 1'b0, ser_busy = 1'b0;
    logic [7:0] stat_rdata;
    logic       cyc_en, lp_active;

    int n_chk = 0, n_fail = 0, n_clk = 0;
    int m_cnt = 0, m_low = 0, m_div = 1, m_swb = 0;
    int gap = 0;
    bit gap_ok = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    clk_rate_mgr dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_ack(irq_ack), .rx_en(rx_en),
        .rx_start(rx_start), .tx_load(tx_load), .isr_pf(isr_pf),
        .isr_hi(isr_hi), .isr_lo(isr_lo), .ser_busy(ser_busy),
        .stat_rdata(stat_rdata), .cyc_en(cyc_en), .lp_active(lp_active)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at clock %0d", tag, act, exp, n_clk);
        end
    endtask

    // Advance the model, wait one clock, then compare every output.
    task automatic tick();
        int od, last;
        bit sb;
        if (!rst_n) begin
            m_cnt = 0; m_low = 0; m_div = 1; m_swb = 0; gap_ok = 0;
        end else begin
            od = m_div;
            last = m_low ? 1023 : 3;
            sb = (m_swb == 1) && (od == 3) && (irq_ack || (rx_en && rx_start) || tx_load);
            if (cfg_we) begin
                m_div = cfg_wdata[7:6];
                m_swb = cfg_wdata[5];
            end
            if (sb) m_div = 1;
            if (m_cnt == last) begin
                m_cnt = 0;
                m_low = (od == 3);
            end else begin
                m_cnt++;
            end
        end
        @(posedge clk);
        #2;
        n_clk++;
        check(m_low ? "R2" : "R1", cyc_en, m_cnt == (m_low ? 1023 : 3));
        check("R2", lp_active, m_low);
        check(cur_tag, cfg_rdata, (m_div << 6) | (m_swb << 5));
        check("R10", stat_rdata, {isr_pf, isr_hi, isr_lo, 4'b0, ser_busy});
        if (rst_n) begin
            gap++;
            if (cyc_en) begin
                if (gap_ok) check("R3", (gap == 4 || gap == 1024), 1);
                gap_ok = 1;
                gap = 0;
            end
        end else begin
            gap = 0;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        cur_tag = "R1";
        run(3);
        rst_n = 1'b1;
        run(40);
        // R2: enter low-power with switchback disabled.
        cur_tag = "R4";
        wr(8'hC0);
        cur_tag = "R2";
        run(2200);
        // R8: triggers with switchback off leave low-power running.
        cur_tag = "R8";
        irq_ack = 1; tick(); irq_ack = 0;
        rx_en = 1; rx_start = 1; tick(); rx_start = 0;
        tx_load = 1; tick(); tx_load = 0;
        run(1100);
        check("R8", lp_active, 1);
        // R5: acknowledged interrupt with switchback on.
        cur_tag = "R5";
        wr(8'hE0);
        run(1500);
        irq_ack = 1; tick(); irq_ack = 0;
        check("R5", cfg_rdata[7:6], 2'b01);
        run(1100);
        check("R5", lp_active, 0);
        // R6: start bit with receiver off, then on.
        cur_tag = "R6";
        wr(8'hE0);
        run(1300);
        rx_en = 0; rx_start = 1; tick(); rx_start = 0;
        check("R6", cfg_rdata[7:6], 2'b11);
        run(700);
        rx_en = 1; rx_start = 1; tick(); rx_start = 0;
        check("R6", cfg_rdata[7:6], 2'b01);
        run(1100);
        // R7: transmit buffer load.
        cur_tag = "R7";
        wr(8'hE0);
        run(1200);
        tx_load = 1; tick(); tx_load = 0;
        check("R7", cfg_rdata[7:6], 2'b01);
        run(1100);
        // R4: software exit from low-power.
        cur_tag = "R4";
        wr(8'hE0);
        run(1600);
        wr(8'h60);
        run(1100);
        check("R4", lp_active, 0);
        // R9: simultaneous write and trigger.
        cur_tag = "R9";
        wr(8'hE0);
        run(1050);
        cfg_we = 1; cfg_wdata = 8'hC0; irq_ack = 1; tick();
        cfg_we = 0; irq_ack = 0;
        check("R9", cfg_rdata, 8'h40);
        run(1100);
        // R8: triggers at standard rate change nothing.
        cur_tag = "R8";
        wr(8'h60);
        tx_load = 1; irq_ack = 1; tick(); tx_load = 0; irq_ack = 0;
        run(20);
        // R10: status patterns.
        cur_tag = "R10";
        for (int p = 0; p < 16; p++) begin
            {isr_pf, isr_hi, isr_lo, ser_busy} = p[3:0];
            run(2);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule